// File: doc/BRIEF.md
# Joint gain and sampling-skew estimator for one interleaved converter channel

This block serves one channel of a time-interleaved converter. Its input is that channel's samples after the offset has been removed. With each sample come two reference values of the known calibration tone: V, the sine, and W, the cosine. The channel is modelled as y = G·V + G·T·W. G is the channel gain. T is the skew term, which is the tone's angular frequency times the channel's timing error.

After a start pulse the block collects a window of L valid samples. It keeps separate running sums of y, V and W for the first half of the window and for the second half. From these six sums it solves the two-unknown linear system in closed form: first T, then G, then the reciprocal of G. All three quotients come from one shared bit-serial divider. The 2/L scaling of the half-window means cancels in every ratio, so only the raw sums are used.

The new estimates replace the old ones only when every denominator is usable. The held estimates drive a one-cycle correction stage that returns (y − T·W)/G for each later sample.

Top module: `tiadc_gain_skew_est`

## Requirements
- R1: After reset, t_est = 0, g_est = 1.0 (value 2^FW), est_vld = 0, est_err = 0, and the correction stage passes y through unchanged.
- R2: A start pulse clears est_vld and est_err on the next cycle. It then accumulates the next L cycles with in_vld high. The first L/2 of these samples go to the first-half sums and the last L/2 go to the second-half sums.
- R3: Using the half-window sums S, the skew estimate is T = (Sy2·Sv1 − Sy1·Sv2)/(Sy1·Sw2 − Sy2·Sw1). It is a signed value with FW fraction bits. Its magnitude is floor(|num|·2^FW/|den|) and its sign is the exclusive-or of the two operand signs.
- R4: The gain estimate is G = Sy1·2^FW / (Sv1·2^FW + T·Sw1), quantised the same way as T. The reciprocal R = 2^FW / G is also formed, quantised the same way, with FW fraction bits.
- R5: Every quotient saturates to ±(2^(RW−1) − 1). The most negative code is never produced.
- R6: If any of the three denominators has magnitude below DEN_MIN, est_err is raised and est_vld stays low. In that case t_est and g_est keep their earlier values, and est_err stays high until the next start.
- R7: After a successful solve, est_vld is high and t_est and g_est are stable until the next start.
- R8: A correction request (corr_in_vld) gives corr_vld on the next cycle. The output is corr_out = floor(((y·2^FW − T·W)·R)/2^(2FW)), saturated to the signed DW-bit range.
- R9: Cycles with in_vld low during accumulation do not change the sums and do not advance the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new estimation window |
| in_vld | input | 1 | Qualifies in_y, in_v and in_w |
| in_y | input | DW | Offset-free channel sample, signed |
| in_v | input | DW | Sine reference sample, signed |
| in_w | input | DW | Cosine reference sample, signed |
| t_est | output | RW | Skew estimate T, signed, FW fraction bits |
| g_est | output | RW | Gain estimate G, signed, FW fraction bits |
| est_vld | output | 1 | Estimates were refreshed by the latest window |
| est_err | output | 1 | Latest window had an unusable denominator |
| corr_in_vld | input | 1 | Qualifies corr_y and corr_w |
| corr_y | input | DW | Sample to correct, signed |
| corr_w | input | DW | Cosine reference for that sample, signed |
| corr_out | output | DW | Corrected sample, signed |
| corr_vld | output | 1 | corr_out is valid |

## Verification
The properties assume two things about the inputs. First, sample values must keep the half-window sums inside the DW+log2(L)-bit accumulators. Second, start and in_vld must hold known values from reset onward. The stimulus meets both: it uses tone amplitudes below full scale with a 16-sample window, and it drives every control input at the falling edge. The hold and error properties also assume that start is not raised in the middle of a solve. The bench only raises start after est_vld or est_err has settled.

// File: rtl/tiadc_gain_skew_est.sv
module tiadc_gain_skew_est #(
  parameter int DW      = 12,
  parameter int LOG2L   = 4,
  parameter int FW      = 12,
  parameter int RW      = 16,
  parameter int DEN_MIN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_y,
  input  logic signed [DW-1:0] in_v,
  input  logic signed [DW-1:0] in_w,
  output logic signed [RW-1:0] t_est,
  output logic signed [RW-1:0] g_est,
  output logic                 est_vld,
  output logic                 est_err,
  input  logic                 corr_in_vld,
  input  logic signed [DW-1:0] corr_y,
  input  logic signed [DW-1:0] corr_w,
  output logic signed [DW-1:0] corr_out,
  output logic                 corr_vld
);
  localparam int L    = 1 << LOG2L;
  localparam int AW   = DW + LOG2L;
  localparam int NW   = 2*AW + FW + RW;
  localparam int QW   = NW + FW;
  localparam int IW   = $clog2(QW + 1);
  localparam int MAXQ = (1 << (RW-1)) - 1;
  localparam int CW   = DW + FW + RW + 2;
  localparam int PW   = CW + RW;
  localparam logic signed [RW-1:0] ONE = RW'(1 << FW);
  localparam logic signed [PW-1:0] OMAX = PW'((1 << (DW-1)) - 1);
  localparam logic signed [PW-1:0] OMIN = -OMAX - PW'(1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_LD, S_DIV} st_t;
  st_t state;

  logic [LOG2L:0] cnt;
  logic signed [AW-1:0] sy1, sy2, sv1, sv2, sw1, sw2;
  logic [1:0] op;
  logic signed [RW-1:0] t_new, g_new, r_est;
  logic [NW:0] rem;
  logic [QW-1:0] dq;
  logic [NW-1:0] dvs;
  logic neg;
  logic [IW-1:0] it;

  logic signed [NW-1:0] ey1, ey2, ev1, ev2, ew1, ew2, et, eg, num, den;
  logic [NW-1:0] num_mag, den_mag;
  assign ey1 = NW'(sy1);
  assign ey2 = NW'(sy2);
  assign ev1 = NW'(sv1);
  assign ev2 = NW'(sv2);
  assign ew1 = NW'(sw1);
  assign ew2 = NW'(sw2);
  assign et  = NW'(t_new);
  assign eg  = NW'(g_new);

  always_comb begin
    case (op)
      2'd0: begin
        num = ey2*ev1 - ey1*ev2;
        den = ey1*ew2 - ey2*ew1;
      end
      2'd1: begin
        num = ey1 <<< FW;
        den = (ev1 <<< FW) + et*ew1;
      end
      2'd2: begin
        num = {{(NW-FW-1){1'b0}}, 1'b1, {FW{1'b0}}};
        den = eg;
      end
      default: begin
        num = '0;
        den = '0;
      end
    endcase
  end
  assign num_mag = num[NW-1] ? -num : num;
  assign den_mag = den[NW-1] ? -den : den;
  wire den_bad = den_mag < NW'(DEN_MIN);

  wire [NW:0] rem_sh = {rem[NW-1:0], dq[QW-1]};
  wire ge = rem_sh >= {1'b0, dvs};
  wire [NW:0] rem_nx = ge ? rem_sh - {1'b0, dvs} : rem_sh;
  wire [RW-1:0] q_sat = (dq > QW'(MAXQ)) ? RW'(MAXQ) : dq[RW-1:0];
  wire signed [RW-1:0] res = neg ? -signed'(q_sat) : signed'(q_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      {sy1, sy2, sv1, sv2, sw1, sw2} <= '0;
      op <= '0;
      t_new <= '0;
      g_new <= ONE;
      t_est <= '0;
      g_est <= ONE;
      r_est <= ONE;
      est_vld <= 1'b0;
      est_err <= 1'b0;
      rem <= '0;
      dq <= '0;
      dvs <= '0;
      neg <= 1'b0;
      it <= '0;
    end else if (start) begin
      state <= S_ACC;
      cnt <= '0;
      {sy1, sy2, sv1, sv2, sw1, sw2} <= '0;
      est_vld <= 1'b0;
      est_err <= 1'b0;
    end else begin
      case (state)
        S_ACC: if (in_vld) begin
          if (!cnt[LOG2L-1]) begin
            sy1 <= sy1 + AW'(in_y);
            sv1 <= sv1 + AW'(in_v);
            sw1 <= sw1 + AW'(in_w);
          end else begin
            sy2 <= sy2 + AW'(in_y);
            sv2 <= sv2 + AW'(in_v);
            sw2 <= sw2 + AW'(in_w);
          end
          cnt <= cnt + 1'b1;
          if (cnt == (LOG2L+1)'(L-1)) begin
            state <= S_LD;
            op <= 2'd0;
          end
        end
        S_LD: if (den_bad) begin
          est_err <= 1'b1;
          state <= S_IDLE;
        end else begin
          rem <= '0;
          dq <= {num_mag, {FW{1'b0}}};
          dvs <= den_mag;
          neg <= num[NW-1] ^ den[NW-1];
          it <= '0;
          state <= S_DIV;
        end
        S_DIV: if (it == IW'(QW)) begin
          state <= S_LD;
          op <= op + 2'd1;
          case (op)
            2'd0: t_new <= res;
            2'd1: g_new <= res;
            default: begin
              t_est <= t_new;
              g_est <= g_new;
              r_est <= res;
              est_vld <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end else begin
          rem <= rem_nx;
          dq <= {dq[QW-2:0], ge};
          it <= it + 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic signed [CW-1:0] ce;
  logic signed [PW-1:0] cp, cs;
  assign ce = (CW'(corr_y) <<< FW) - CW'(t_est) * CW'(corr_w);
  assign cp = PW'(ce) * PW'(r_est);
  assign cs = cp >>> (2*FW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_out <= '0;
      corr_vld <= 1'b0;
    end else begin
      corr_vld <= corr_in_vld;
      if (corr_in_vld)
        corr_out <= (cs > OMAX) ? DW'(OMAX) : (cs < OMIN) ? DW'(OMIN) : DW'(cs);
    end
  end

  p_vld_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(est_vld && est_err));
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n) start |=> (!est_vld && !est_err));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (est_vld && !start) |=> (est_vld && $stable(t_est) && $stable(g_est)));
  p_err_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LD && den_bad && !start) |=> (est_err && !est_vld && $stable(t_est) && $stable(g_est)));
  p_no_min_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_est != {1'b1, {(RW-1){1'b0}}}) && (g_est != {1'b1, {(RW-1){1'b0}}}));
  p_corr_lat_r8: assert property (@(posedge clk) disable iff (!rst_n) corr_in_vld |=> corr_vld);
  p_corr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) !corr_in_vld |=> !corr_vld);
endmodule

// File: tb/sim_tiadc_gain_skew_est.sv
module sim_tiadc_gain_skew_est;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_vld = 1'b0, corr_in_vld = 1'b0;
  logic signed [11:0] in_y = '0, in_v = '0, in_w = '0, corr_y = '0, corr_w = '0;
  logic signed [15:0] t_est, g_est;
  logic est_vld, est_err, corr_vld;
  logic signed [11:0] corr_out;

  int checks = 0, errors = 0;
  longint ys[16], vs[16], ws[16];
  longint et = 0, eg = 4096, er = 4096;

  always #2 clk = ~clk;

  tiadc_gain_skew_est u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vld(in_vld),
    .in_y(in_y), .in_v(in_v), .in_w(in_w),
    .t_est(t_est), .g_est(g_est), .est_vld(est_vld), .est_err(est_err),
    .corr_in_vld(corr_in_vld), .corr_y(corr_y), .corr_w(corr_w),
    .corr_out(corr_out), .corr_vld(corr_vld));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint qdiv(longint n, longint d);
    longint an = (n < 0) ? -n : n;
    longint ad = (d < 0) ? -d : d;
    longint q = (an <<< 12) / ad;
    if (q > 32767) q = 32767;
    return ((n < 0) != (d < 0)) ? -q : q;
  endfunction

  function automatic longint absl(longint x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic longint rnd(real x);
    return longint'($rtoi(x + ((x >= 0.0) ? 0.5 : -0.5)));
  endfunction

  task automatic tone(input real g, input real t, input real f);
    for (int n = 0; n < 16; n++) begin
      real s = $sin(6.283185307 * f * n);
      real c = $cos(6.283185307 * f * n);
      vs[n] = rnd(1400.0 * s);
      ws[n] = rnd(1400.0 * c);
      ys[n] = rnd(1400.0 * g * (s + t * c));
    end
  endtask

  task automatic run_window(input bit gaps, input string tag);
    longint sy1 = 0, sy2 = 0, sv1 = 0, sv2 = 0, sw1 = 0, sw2 = 0;
    longint dt, nt, tn, dg, gn, rn;
    bit xerr = 0;
    int guard = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!est_vld && !est_err, "R2 start clears flags", {est_vld, est_err}, 0);
    for (int n = 0; n < 16; n++) begin
      in_vld = 1'b1; in_y = 12'(ys[n]); in_v = 12'(vs[n]); in_w = 12'(ws[n]);
      @(negedge clk);
      if (gaps && (n % 3 == 0)) begin
        in_vld = 1'b0; in_y = 12'sd2047; in_v = -12'sd2048; in_w = 12'sd2047;
        @(negedge clk);
      end
      if (n < 8) begin sy1 += ys[n]; sv1 += vs[n]; sw1 += ws[n]; end
      else begin sy2 += ys[n]; sv2 += vs[n]; sw2 += ws[n]; end
    end
    in_vld = 1'b0;
    nt = sy2*sv1 - sy1*sv2;
    dt = sy1*sw2 - sy2*sw1;
    if (absl(dt) < 16) xerr = 1;
    else begin
      tn = qdiv(nt, dt);
      dg = (sv1 <<< 12) + tn*sw1;
      if (absl(dg) < 16) xerr = 1;
      else begin
        gn = qdiv(sy1 <<< 12, dg);
        if (absl(gn) < 16) xerr = 1;
        else rn = qdiv(4096, gn);
      end
    end
    while (!est_vld && !est_err && guard < 2000) begin @(negedge clk); guard++; end
    check(guard < 2000, {"R2 window completes ", tag}, guard, 0);
    check(est_err == xerr, {"R6 error flag ", tag}, est_err, xerr);
    check(est_vld == !xerr, {"R7 valid flag ", tag}, est_vld, !xerr);
    if (!xerr) begin et = tn; eg = gn; er = rn; end
    check(t_est == et, {"R3 skew ", tag}, t_est, et);
    check(g_est == eg, {"R4 gain ", tag}, g_est, eg);
  endtask

  task automatic corr_chk(input longint y, input longint w, input string tag);
    longint e, p, q;
    @(negedge clk); corr_in_vld = 1'b1; corr_y = 12'(y); corr_w = 12'(w);
    @(negedge clk); corr_in_vld = 1'b0;
    e = (y <<< 12) - et*w;
    p = e*er;
    q = p >>> 24;
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    check(corr_vld && corr_out == q, {"R8 correction ", tag}, corr_out, q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    real gl[3] = '{0.8, 1.0, 1.3};
    real tl[3] = '{-0.05, 0.0, 0.03};
    real fl[2] = '{3.0/37.0, 5.0/53.0};
    repeat (3) @(negedge clk);
    check(t_est == 0, "R1 reset skew", t_est, 0);
    check(g_est == 4096, "R1 reset gain", g_est, 4096);
    check(!est_vld && !est_err, "R1 reset flags", {est_vld, est_err}, 0);
    rst_n = 1'b1;
    corr_chk(1234, 500, "R1 identity");
    corr_chk(-777, -2048, "R1 identity neg");

    for (int gi = 0; gi < 3; gi++)
      for (int ti = 0; ti < 3; ti++)
        for (int fi = 0; fi < 2; fi++) begin
          tone(gl[gi], tl[ti], fl[fi]);
          run_window((gi + ti + fi) % 2 == 1, "R9 sweep");
          corr_chk(ys[3], ws[3], "sweep");
          corr_chk(2047, 0, "sweep high");
          corr_chk(-2048, 2047, "sweep low");
        end

    tone(1.0, 0.02, 3.0/37.0);
    run_window(1'b0, "R7 base");
    repeat (20) @(negedge clk);
    check(est_vld && t_est == et && g_est == eg, "R7 hold", t_est, et);

    for (int n = 0; n < 16; n++) begin ys[n] = 0; vs[n] = 100; ws[n] = (n < 8) ? 50 : -50; end
    run_window(1'b0, "R6 zero denominator");
    check(est_err && t_est == et, "R6 previous kept", t_est, et);

    for (int n = 0; n < 16; n++) begin ys[n] = 2000; vs[n] = 1; ws[n] = (n < 8) ? 100 : -100; end
    run_window(1'b1, "R5 positive");
    check(g_est == 32767, "R5 saturate high", g_est, 32767);
    corr_chk(1000, 0, "R5 small gain recip");
    for (int n = 0; n < 16; n++) ys[n] = -2000;
    run_window(1'b0, "R5 negative");
    check(g_est == -32767, "R5 saturate low", g_est, -32767);
    corr_chk(-1500, 300, "R5 negative gain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule